// File: doc/BRIEF.md
# Serial Byte-Memory Slave Front End

This block sits between a four-wire mode-0 serial bus and a 512-byte synchronous memory with no write delay. The bus master lowers chip select and shifts in a command byte. For the two memory commands the ninth address bit rides inside that command byte, and one more byte supplies the low eight address bits. After that the block streams data. On a write it commits each byte to the memory port as soon as its eighth bit arrives. On a read it fetches each byte and shifts it out on the serial output, most significant bit first. In both directions the address steps by one per byte and wraps from the top of the array to zero. No page buffer is used, so a frame may carry any number of bytes.

A write-enable command, sent in an earlier frame, arms a latch. A write frame disarms it when chip select rises. An active-low protect pin also blocks array writes. A change on that pin takes effect only at the next byte boundary. An active-low hold pin, sampled only while the serial clock is low, freezes a transfer without ending it. All bus pins are sampled by the system clock through a synchronizer. The serial output is returned as a value plus an output-enable, and the pad logic turns these into a tri-state driver.

Top module: `sermem_spi_slave`

## Requirements
- R1: After reset the output-enable is low, neither memory strobe is asserted and the write-enable latch is clear.
- R2: The write command byte is binary 0000_A_010 and the read command byte is 0000_A_011, where bit 3 (A) is address bit 8. The next byte gives address bits 7..0. Every byte travels MSB first and is sampled on rising SCK.
- R3: Command byte 06h sets the write-enable latch. While the latch is clear, no write frame produces a memory write strobe.
- R4: Each write data byte gets exactly one memory write strobe, carrying that byte, before the next SCK rise. A frame may hold any number of bytes, and the address advances by one after each byte.
- R5: The address wraps from 1FFh to 000h on both writes and reads.
- R6: In a read, each data bit is placed on the serial output at a falling SCK edge, MSB first, and SI is ignored after the address byte. The output-enable is high only during the read data phase.
- R7: When the protect pin is low at the first bit of a data byte, that byte is not written. A change of the pin partway through a byte applies from the next byte.
- R8: The latch clears when chip select rises at the end of a frame that carried a write command. A read frame or an unrecognised frame leaves it set.
- R9: A data byte cut short by chip select rising before its eighth bit is not written.
- R10: While hold is in force, SCK edges neither shift nor emit bits and the output-enable is low. After release the transfer continues where it stopped.
- R11: After an unrecognised command byte, the rest of the frame is ignored until chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data from the master |
| wp_n | input | 1 | Active-low write protect |
| hold_n | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data value to the master |
| so_oe | output | 1 | Drive enable for the serial output pad; low means high impedance |
| mem_addr | output | 9 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_re | output | 1 | One-cycle memory read strobe; data is expected on mem_rdata the next cycle |
| mem_rdata | input | 8 | Memory read data |

## Verification
Every bus pin passes through two synchronizer flops and one edge flop. The memory write strobe for a byte therefore appears three clocks after the raw eighth rising SCK edge, and a read strobe follows the same count, with data loaded two clocks later. A serial output bit settles three clocks after the raw falling SCK edge. The bench holds each SCK phase for six clocks. It checks memory contents when the high phase ends and samples the serial output at the end of the low phase, so every result is due well before the bench looks at it. Hold and protect changes are made while SCK is low, and their effect is judged only on later bytes.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

  localparam int SM_AW     = 9;
  localparam int SM_DW     = 8;
  localparam int SM_BIT_CW = $clog2(SM_DW);

  typedef logic [SM_AW-1:0]     sm_addr_t;
  typedef logic [SM_DW-1:0]     sm_byte_t;
  typedef logic [SM_BIT_CW-1:0] sm_bit_t;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } sm_phase_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_ARM,
    OP_WRITE,
    OP_READ
  } sm_op_e;

  localparam sm_byte_t OPC_ARM = 8'h06;

  // classify a command byte; bit 3 of read/write opcodes is address bit 8
  function automatic sm_op_e decode_op(sm_byte_t b);
    if (b == OPC_ARM)                          return OP_ARM;
    if (b[7:4] == 4'h0 && b[2:0] == 3'b010)    return OP_WRITE;
    if (b[7:4] == 4'h0 && b[2:0] == 3'b011)    return OP_READ;
    return OP_NONE;
  endfunction

  function automatic logic op_addr_msb(sm_byte_t b);
    return b[3];
  endfunction

  // sequential address step, wrapping naturally at the array top
  function automatic sm_addr_t next_addr(sm_addr_t a);
    return a + sm_addr_t'(1);
  endfunction

  // which bit of the outgoing byte is shown after a given count of rises
  function automatic sm_bit_t tx_bit_index(sm_bit_t rises);
    return sm_bit_t'(SM_DW - 1) - rises;
  endfunction

endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  if (STAGES == 0) begin : g_bypass
    assign q = d;
  end else begin : g_chain
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
      end else begin
        pipe[0] <= d;
        for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
    end

    assign q = pipe[STAGES-1];
  end

endmodule

// File: rtl/sermem_pace.sv
module sermem_pace (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic hold_n_s,
  input  logic cs_act,
  output logic rise,
  output logic fall,
  output logic held
);

  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      held  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      // the pause pin only counts while the serial clock sits low
      if (!sck_s) held <= !hold_n_s;
    end
  end

  assign rise = sck_s & ~sck_q & ~held & cs_act;
  assign fall = ~sck_s & sck_q & ~held & cs_act;

endmodule

// File: rtl/sermem_core.sv
module sermem_core
  import sermem_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_act,
  input  logic      rise,
  input  logic      fall,
  input  logic      held,
  input  logic      si_s,
  input  logic      wp_n_s,
  input  sm_byte_t  mem_rdata,
  output sm_addr_t  mem_addr,
  output sm_byte_t  mem_wdata,
  output logic      mem_we,
  output logic      mem_re,
  output logic      so,
  output logic      so_oe,
  output logic      wel,
  output logic      byte_done,
  output logic      addr_adv,
  output sm_bit_t   bit_cnt,
  output sm_addr_t  cur_addr
);

  sm_phase_e phase;
  sm_byte_t  shreg;
  sm_byte_t  rd_byte;
  logic      a8_q;
  logic      cmd_wr;
  logic      cmd_rd;
  logic      wp_ok_q;
  logic      re_d;
  logic      so_q;
  logic      so_started;
  logic      cs_act_q;

  sm_byte_t  rx_byte;
  sm_op_e    op;
  logic      frame_end;
  logic      wr_commit;

  assign rx_byte   = {shreg[SM_DW-2:0], si_s};
  assign op        = decode_op(rx_byte);
  assign byte_done = rise && (bit_cnt == sm_bit_t'(SM_DW - 1));
  assign frame_end = cs_act_q && !cs_act;
  assign addr_adv  = byte_done && (phase == PH_WDATA || phase == PH_RDATA);
  assign wr_commit = byte_done && (phase == PH_WDATA) && wel && wp_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      shreg      <= '0;
      rd_byte    <= '0;
      bit_cnt    <= '0;
      cur_addr   <= '0;
      a8_q       <= 1'b0;
      cmd_wr     <= 1'b0;
      cmd_rd     <= 1'b0;
      wel        <= 1'b0;
      wp_ok_q    <= 1'b0;
      re_d       <= 1'b0;
      so_q       <= 1'b0;
      so_started <= 1'b0;
      cs_act_q   <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
    end else begin
      cs_act_q <= cs_act;
      mem_we   <= 1'b0;
      mem_re   <= 1'b0;
      re_d     <= mem_re;
      if (re_d) rd_byte <= mem_rdata;

      if (frame_end && cmd_wr) wel <= 1'b0;

      if (!cs_act) begin
        phase      <= PH_CMD;
        bit_cnt    <= '0;
        cmd_wr     <= 1'b0;
        cmd_rd     <= 1'b0;
        so_started <= 1'b0;
      end else begin
        if (rise) begin
          shreg   <= rx_byte;
          bit_cnt <= bit_cnt + sm_bit_t'(1);
          if (bit_cnt == '0) wp_ok_q <= wp_n_s;
        end

        if (fall && phase == PH_RDATA) begin
          so_q       <= rd_byte[tx_bit_index(bit_cnt)];
          so_started <= 1'b1;
        end

        if (byte_done) begin
          unique case (phase)
            PH_CMD: begin
              unique case (op)
                OP_ARM: begin
                  wel   <= 1'b1;
                  phase <= PH_SKIP;
                end
                OP_WRITE: begin
                  a8_q   <= op_addr_msb(rx_byte);
                  cmd_wr <= 1'b1;
                  phase  <= PH_ADDR;
                end
                OP_READ: begin
                  a8_q   <= op_addr_msb(rx_byte);
                  cmd_rd <= 1'b1;
                  phase  <= PH_ADDR;
                end
                default: phase <= PH_SKIP;
              endcase
            end
            PH_ADDR: begin
              cur_addr <= {a8_q, rx_byte};
              if (cmd_rd) begin
                mem_addr <= {a8_q, rx_byte};
                mem_re   <= 1'b1;
                phase    <= PH_RDATA;
              end else begin
                phase <= PH_WDATA;
              end
            end
            PH_WDATA: begin
              if (wr_commit) begin
                mem_we    <= 1'b1;
                mem_addr  <= cur_addr;
                mem_wdata <= rx_byte;
              end
              cur_addr <= next_addr(cur_addr);
            end
            PH_RDATA: begin
              cur_addr <= next_addr(cur_addr);
              mem_addr <= next_addr(cur_addr);
              mem_re   <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign so    = so_q;
  assign so_oe = so_started && !held;

endmodule

// File: rtl/sermem_spi_slave.sv
module sermem_spi_slave
  import sermem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       wp_n,
  input  logic       hold_n,
  output logic       so,
  output logic       so_oe,
  output logic [8:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       mem_we,
  output logic       mem_re,
  input  logic [7:0] mem_rdata
);

  localparam int          NPIN     = 5;
  localparam logic [NPIN-1:0] PIN_RST = 5'b10011; // cs_n, sck, si, wp_n, hold_n

  logic [NPIN-1:0] pins_s;
  logic cs_n_s, sck_s, si_s, wp_n_s, hold_n_s;

  // internal events, named for the checker
  logic     cs_act;
  logic     sck_rise;
  logic     sck_fall;
  logic     held;
  logic     wel;
  logic     byte_done;
  logic     addr_adv;
  sm_bit_t  bit_cnt;
  sm_addr_t cur_addr;

  sermem_sync #(
    .WIDTH  (NPIN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, sck, si, wp_n, hold_n}),
    .q    (pins_s)
  );

  assign {cs_n_s, sck_s, si_s, wp_n_s, hold_n_s} = pins_s;
  assign cs_act = !cs_n_s;

  sermem_pace u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_s   (sck_s),
    .hold_n_s(hold_n_s),
    .cs_act  (cs_act),
    .rise    (sck_rise),
    .fall    (sck_fall),
    .held    (held)
  );

  sermem_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .rise     (sck_rise),
    .fall     (sck_fall),
    .held     (held),
    .si_s     (si_s),
    .wp_n_s   (wp_n_s),
    .mem_rdata(mem_rdata),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .so       (so),
    .so_oe    (so_oe),
    .wel      (wel),
    .byte_done(byte_done),
    .addr_adv (addr_adv),
    .bit_cnt  (bit_cnt),
    .cur_addr (cur_addr)
  );

endmodule

// File: rtl/sermem_spi_slave_chk.sv
module sermem_spi_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       held,
  input logic       wel,
  input logic       addr_adv,
  input logic [2:0] bit_cnt,
  input logic [8:0] cur_addr,
  input logic       mem_we,
  input logic       mem_re,
  input logic       so_oe
);

  // R3: a write strobe only while the enable latch is set
  p_we_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel);

  // R4: one strobe per byte, never back to back
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R4: the memory port never reads and writes in one cycle
  p_port_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R5: stepping past the top address lands on zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_adv && cur_addr == 9'h1FF) |=> (cur_addr == 9'h000));

  // R6: output released once chip select has been inactive two cycles
  p_so_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> !so_oe);

  // R10: a paused transfer does not move its bit position
  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (held && cs_act) |=> $stable(bit_cnt));

  // R10: no drive while paused
  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe);

endmodule

bind sermem_spi_slave sermem_spi_slave_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_act  (cs_act),
  .held    (held),
  .wel     (wel),
  .addr_adv(addr_adv),
  .bit_cnt (bit_cnt),
  .cur_addr(cur_addr),
  .mem_we  (mem_we),
  .mem_re  (mem_re),
  .so_oe   (so_oe)
);

// File: tb/sermem_spi_slave_test.sv
`timescale 1ns/1ps
module sermem_spi_slave_test;

  localparam int H = 6; // clocks per SCK phase

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
  logic so, so_oe, mem_we, mem_re;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;

  logic [7:0] mem     [512];
  logic [7:0] exp_mem [512];
  int n_tests = 0, n_fail = 0, we_count = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sermem_spi_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .hold_n(hold_n), .so(so), .so_oe(so_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_count = we_count + 1;
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(logic v);
    si = v; idle(H); sck = 1'b1; idle(H); sck = 1'b0;
  endtask

  task automatic spi_tx(logic [7:0] b);
    for (int i = 7; i >= 0; i--) spi_bit(b[i]);
  endtask

  task automatic spi_rx(output logic [7:0] b, output logic oe_ok);
    oe_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      si = ~si; idle(H);
      b[i] = so;
      if (so_oe !== 1'b1) oe_ok = 1'b0;
      sck = 1'b1; idle(H); sck = 1'b0;
    end
  endtask

  task automatic cs_lo(); cs_n = 1'b0; idle(H); endtask
  task automatic cs_hi(); idle(H); cs_n = 1'b1; idle(3*H); endtask

  task automatic arm();
    cs_lo(); spi_tx(8'h06); cs_hi();
  endtask

  task automatic wr_hdr(logic [8:0] a);
    spi_tx({4'h0, a[8], 3'b010}); spi_tx(a[7:0]);
  endtask

  task automatic rd_hdr(logic [8:0] a);
    spi_tx({4'h0, a[8], 3'b011}); spi_tx(a[7:0]);
  endtask

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 11) ^ (k >> 3));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    logic ok;
    int base;
    for (int i = 0; i < 512; i++) begin mem[i] = 8'hEE; exp_mem[i] = 8'hEE; end

    idle(10); rst_n = 1'b1; idle(4);
    chk("R1", "so_oe after reset", so_oe, 0);
    chk("R1", "mem_we after reset", mem_we, 0);
    chk("R1", "mem_re after reset", mem_re, 0);

    // R3: write with no earlier arm frame
    cs_lo(); wr_hdr(9'h020); spi_tx(8'h3C); cs_hi();
    chk("R3", "no strobe without arm", we_count, 0);
    chk("R3", "mem[020] untouched", mem[9'h020], 8'hEE);

    // R2/R3: armed write with address bit 8 set
    arm();
    cs_lo(); wr_hdr(9'h123);
    chk("R6", "so_oe in write frame", so_oe, 0);
    spi_tx(8'hA1); spi_tx(8'hB2); cs_hi();
    exp_mem[9'h123] = 8'hA1; exp_mem[9'h124] = 8'hB2;
    chk("R2", "mem[123]", mem[9'h123], 8'hA1);
    chk("R2", "mem[124]", mem[9'h124], 8'hB2);
    chk("R2", "mem[023] untouched", mem[9'h023], 8'hEE);

    // R8: latch cleared by the write frame end
    base = we_count;
    cs_lo(); wr_hdr(9'h124); spi_tx(8'h00); cs_hi();
    chk("R8", "no strobe after write frame", we_count - base, 0);
    chk("R8", "mem[124] kept", mem[9'h124], 8'hB2);

    // R8/R6: read frame leaves latch set
    arm();
    cs_lo(); rd_hdr(9'h123);
    spi_rx(rb, ok); chk("R6", "read byte 0", rb, 8'hA1); chk("R6", "so_oe in read", ok, 1);
    spi_rx(rb, ok); chk("R6", "read byte 1", rb, 8'hB2);
    cs_hi();
    chk("R6", "so_oe after read frame", so_oe, 0);
    cs_lo(); wr_hdr(9'h050); spi_tx(8'h77); cs_hi();
    exp_mem[9'h050] = 8'h77;
    chk("R8", "write after read frame", mem[9'h050], 8'h77);

    // R9: partial byte
    arm();
    cs_lo(); wr_hdr(9'h060); spi_tx(8'h11);
    for (int i = 0; i < 5; i++) spi_bit(1'b1);
    cs_hi();
    exp_mem[9'h060] = 8'h11;
    chk("R9", "full byte kept", mem[9'h060], 8'h11);
    chk("R9", "partial byte dropped", mem[9'h061], 8'hEE);

    // R11: unrecognised opcodes
    arm();
    base = we_count;
    cs_lo(); spi_tx(8'h55); spi_tx(8'h02); spi_tx(8'h70); spi_tx(8'hAA); cs_hi();
    cs_lo(); spi_tx(8'h12); spi_tx(8'h70); spi_tx(8'hAB); cs_hi();
    chk("R11", "no strobe after bad opcode", we_count - base, 0);
    chk("R11", "mem[070] untouched", mem[9'h070], 8'hEE);
    cs_lo(); wr_hdr(9'h071); spi_tx(8'h5D); cs_hi();
    exp_mem[9'h071] = 8'h5D;
    chk("R11", "latch kept after bad frame", mem[9'h071], 8'h5D);

    // R7: protect pin low for whole frame
    arm(); wp_n = 1'b0; idle(4);
    cs_lo(); wr_hdr(9'h080); spi_tx(8'h99); cs_hi();
    chk("R7", "protected write blocked", mem[9'h080], 8'hEE);
    // R7: protect lowered mid byte
    wp_n = 1'b1; arm();
    cs_lo(); wr_hdr(9'h090); spi_tx(8'h01);
    for (int i = 7; i >= 4; i--) spi_bit(1'(8'h02 >> i));
    wp_n = 1'b0;
    for (int i = 3; i >= 0; i--) spi_bit(1'(8'h02 >> i));
    spi_tx(8'h03); cs_hi(); wp_n = 1'b1;
    exp_mem[9'h090] = 8'h01; exp_mem[9'h091] = 8'h02;
    chk("R7", "byte before change", mem[9'h090], 8'h01);
    chk("R7", "byte in flight", mem[9'h091], 8'h02);
    chk("R7", "byte after change", mem[9'h092], 8'hEE);

    // R10: hold inside a write byte
    arm();
    cs_lo(); wr_hdr(9'h0A0);
    for (int i = 7; i >= 5; i--) spi_bit(1'(8'hC6 >> i));
    hold_n = 1'b0; idle(2*H);
    for (int i = 0; i < 3; i++) spi_bit(i[0]);
    hold_n = 1'b1; idle(2*H);
    for (int i = 4; i >= 0; i--) spi_bit(1'(8'hC6 >> i));
    spi_tx(8'h3B); cs_hi();
    exp_mem[9'h0A0] = 8'hC6; exp_mem[9'h0A1] = 8'h3B;
    chk("R10", "held write byte", mem[9'h0A0], 8'hC6);
    chk("R10", "byte after resume", mem[9'h0A1], 8'h3B);
    // R10: hold inside a read
    cs_lo(); rd_hdr(9'h0A0);
    spi_rx(rb, ok); chk("R10", "read before hold", rb, 8'hC6);
    hold_n = 1'b0; idle(2*H);
    chk("R10", "so_oe during hold", so_oe, 0);
    for (int i = 0; i < 4; i++) spi_bit(1'b1);
    hold_n = 1'b1; idle(2*H);
    spi_rx(rb, ok); chk("R10", "read after resume", rb, 8'h3B);
    cs_hi();

    // R4/R5: long write frame crossing the top address
    arm();
    base = we_count;
    cs_lo(); wr_hdr(9'h1F0);
    for (int k = 0; k < 520; k++) begin
      logic [8:0] a;
      a = 9'((9'h1F0 + k) % 512);
      spi_tx(pat(k));
      exp_mem[a] = pat(k);
      chk("R4", "streamed byte", mem[a], pat(k));
    end
    cs_hi();
    chk("R4", "strobe count", we_count - base, 520);
    for (int a = 0; a < 512; a++) chk("R5", "array after wrap", mem[a], exp_mem[a]);

    // R5/R6: long read frame crossing the top address
    cs_lo(); rd_hdr(9'h1FC);
    for (int k = 0; k < 516; k++) begin
      spi_rx(rb, ok);
      chk("R5", "streamed read", rb, exp_mem[(9'h1FC + k) % 512]);
    end
    cs_hi();
    chk("R6", "so_oe idle at end", so_oe, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule